// File: doc/BRIEF.md
# Dual-Bank General Register File

This block stores the working registers of a 16-bit processor core. It holds two identical banks. Each bank has four data registers (D0 to D3), two address registers (AD0, AD1) and a frame base register (FRM). All of them are 16 bits wide. Bit 4 of a shared flag word picks the bank that every register access uses. The flag word, a user stack pointer and an interrupt stack pointer are held only once, and both banks share them. Bit 7 of the flag word chooses which stack pointer the alias selector reaches.

Two combinational read ports and one clocked write port share the same encoding. The selector codes are: 0 D0, 1 D1, 2 D2, 3 D3, 4 AD0, 5 AD1, 6 FRM, 7 flags, 8 user SP, 9 interrupt SP, and 10 the active SP. The size codes are: 0 word, 1 byte, 2 long, 3 reserved. A half bit picks the byte: 1 is bits 15..8, 0 is bits 7..0. Word and byte results come out zero-extended on the 32-bit read data. A long access reaches a fixed pair. Byte write data is taken from bits 7..0 of the write data.

Top module: `gpr_bank_file`

## Requirements
- R1: After reset, every register of both banks, both stack pointers and the flag word read as zero, so bank 0 and the interrupt stack pointer are selected.
- R2: A word write (size 0) to selectors 0..6 updates that register of the active bank from write data bits 15..0. A word read returns the register in bits 15..0 and zero in bits 31..16.
- R3: Byte access (size 1) works on D0 and D1 only. Half 1 reaches bits 15..8 and half 0 reaches bits 7..0. A byte write leaves the other byte unchanged, and a byte read is zero-extended to 32 bits.
- R4: A long access (size 2) on selector 0 reaches D2:D0, on selector 1 reaches D3:D1, and on selector 4 reaches AD1:AD0. The first-named register is the upper word, and both words are written in the same cycle.
- R5: A byte access to any selector other than 0 or 1, a long access to any selector other than 0, 1 or 4, and any access with size 3 change nothing and read as zero.
- R6: Flag bit 4 selects the bank, and a change to it takes effect on the cycle after the flag write. Writes never alter the bank that is not selected.
- R7: The flag word keeps only bits 7..0 (the single flags) and bits 14..12 (the priority level). All other bits read as zero whatever is written to them.
- R8: Selector 8 is the user SP and selector 9 is the interrupt SP. Selector 10 reaches the interrupt SP when flag bit 7 is 0 and the user SP when it is 1. Both pointers are the same in either bank.
- R9: A read of a register that is being written in the same cycle returns the value from before the write.
- R10: The two read ports decode their selector, size and half on their own, so both can read different registers with different sizes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdSelA | input | 4 | Port A register selector |
| rdSizeA | input | 2 | Port A access size |
| rdHighA | input | 1 | Port A byte half |
| rdDataA | output | 32 | Port A read data |
| rdSelB | input | 4 | Port B register selector |
| rdSizeB | input | 2 | Port B access size |
| rdHighB | input | 1 | Port B byte half |
| rdDataB | output | 32 | Port B read data |
| wrEn | input | 1 | Write enable |
| wrSel | input | 4 | Write register selector |
| wrSize | input | 2 | Write access size |
| wrHigh | input | 1 | Write byte half |
| wrData | input | 32 | Write data |
| flagsOut | output | 16 | Current flag word |

## Verification
The first pattern writes a distinct word to every selector. This separates the seven bank registers and catches any aliasing between them. Byte writes to the upper and then the lower half, each followed by a word read, show whether the other half is kept. Long writes with different upper and lower words show whether each pair has the right register in the upper slot. Bank and stack switching are tried with markers written into both banks and both pointers, which separates a shared register from one held per bank. Reads taken in the same cycle as a write separate the old value from the new one.

// File: rtl/gpr_bank_pkg.sv
package gpr_bank_pkg;
  localparam int WORD_W   = 16;
  localparam int BANK_REGS = 7;
  localparam int NUM_BANKS = 2;
  localparam int SEL_W    = 4;
  localparam int NUM_RD   = 2;
  localparam int LONG_W   = 2 * WORD_W;
  localparam int BYTE_W   = WORD_W / 2;

  localparam logic [SEL_W-1:0] SEL_D0  = 4'd0;
  localparam logic [SEL_W-1:0] SEL_D1  = 4'd1;
  localparam logic [SEL_W-1:0] SEL_D2  = 4'd2;
  localparam logic [SEL_W-1:0] SEL_D3  = 4'd3;
  localparam logic [SEL_W-1:0] SEL_AD0 = 4'd4;
  localparam logic [SEL_W-1:0] SEL_AD1 = 4'd5;
  localparam logic [SEL_W-1:0] SEL_FRM = 4'd6;
  localparam logic [SEL_W-1:0] SEL_FLG = 4'd7;
  localparam logic [SEL_W-1:0] SEL_USP = 4'd8;
  localparam logic [SEL_W-1:0] SEL_ISP = 4'd9;
  localparam logic [SEL_W-1:0] SEL_SP  = 4'd10;

  localparam int BANK_BIT  = 4;
  localparam int STACK_BIT = 7;
  localparam logic [WORD_W-1:0] FLAG_KEEP = 16'h70FF;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_LONG = 2'd2,
    SZ_NONE = 2'd3
  } accSize_e;

  typedef struct packed {
    logic [BANK_REGS-1:0] loEn;
    logic [BANK_REGS-1:0] hiEn;
    logic [BANK_REGS-1:0] takeUpper;
    logic                 byteDup;
    logic                 flagEn;
    logic                 uspEn;
    logic                 ispEn;
  } wrStrobe_t;
endpackage

// File: rtl/gpr_bank_ctrl.sv
module gpr_bank_ctrl
  import gpr_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [1:0]       wrSize,
  input  logic             wrHigh,
  input  logic             stackSel,
  output wrStrobe_t        st
);
  accSize_e sizeE;
  assign sizeE = accSize_e'(wrSize);

  always_comb begin
    st = '0;
    if (wrEn) begin
      unique case (sizeE)
        SZ_WORD: begin
          if (wrSel <= SEL_FRM) begin
            st.loEn[wrSel[2:0]] = 1'b1;
            st.hiEn[wrSel[2:0]] = 1'b1;
          end else if (wrSel == SEL_FLG) begin
            st.flagEn = 1'b1;
          end else if (wrSel == SEL_USP) begin
            st.uspEn = 1'b1;
          end else if (wrSel == SEL_ISP) begin
            st.ispEn = 1'b1;
          end else if (wrSel == SEL_SP) begin
            st.uspEn = stackSel;
            st.ispEn = !stackSel;
          end
        end
        SZ_BYTE: begin
          if (wrSel == SEL_D0 || wrSel == SEL_D1) begin
            st.byteDup = 1'b1;
            if (wrHigh) st.hiEn[wrSel[2:0]] = 1'b1;
            else        st.loEn[wrSel[2:0]] = 1'b1;
          end
        end
        SZ_LONG: begin
          if (wrSel == SEL_D0 || wrSel == SEL_D1 || wrSel == SEL_AD0) begin
            st.loEn[wrSel[2:0]]      = 1'b1;
            st.hiEn[wrSel[2:0]]      = 1'b1;
            st.loEn[wrSel[2:0] + 3'd2] = (wrSel != SEL_AD0);
            st.hiEn[wrSel[2:0] + 3'd2] = (wrSel != SEL_AD0);
            st.takeUpper[wrSel[2:0] + 3'd2] = (wrSel != SEL_AD0);
            if (wrSel == SEL_AD0) begin
              st.loEn[SEL_AD1[2:0]]      = 1'b1;
              st.hiEn[SEL_AD1[2:0]]      = 1'b1;
              st.takeUpper[SEL_AD1[2:0]] = 1'b1;
            end
          end
        end
        default: st = '0;
      endcase
    end
  end

  // R3: byte writes never reach registers beyond D0/D1
  p_byte_low_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && sizeE == SZ_BYTE) |-> (((st.loEn | st.hiEn) & 7'b1111100) == '0));

  // R4: a legal long write strobes exactly two full words
  p_long_two_words_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && sizeE == SZ_LONG && (wrSel == SEL_D0 || wrSel == SEL_D1 || wrSel == SEL_AD0))
      |-> ($countones(st.loEn & st.hiEn) == 2 && $countones(st.takeUpper) == 1));

  // R5: reserved size touches nothing
  p_none_size_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sizeE == SZ_NONE) |-> (st == '0));
endmodule

// File: rtl/gpr_bank_dp.sv
module gpr_bank_dp
  import gpr_bank_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  wrStrobe_t                    st,
  input  logic [LONG_W-1:0]            wrData,
  input  logic [NUM_RD-1:0][SEL_W-1:0] rdSel,
  input  logic [NUM_RD-1:0][1:0]       rdSize,
  input  logic [NUM_RD-1:0]            rdHigh,
  output logic [NUM_RD-1:0][LONG_W-1:0] rdData,
  output logic [WORD_W-1:0]            flags,
  output logic                         stackSel
);
  logic [NUM_BANKS-1:0][BANK_REGS-1:0][WORD_W-1:0] bankRegs;
  logic [BANK_REGS-1:0][WORD_W-1:0] cur;
  logic [BANK_REGS-1:0][WORD_W-1:0] dIn;
  logic [WORD_W-1:0] uspQ, ispQ;
  logic curBank;

  assign curBank  = flags[BANK_BIT];
  assign stackSel = flags[STACK_BIT];
  assign cur      = bankRegs[curBank];

  always_comb begin
    for (int i = 0; i < BANK_REGS; i++) begin
      if (st.takeUpper[i])  dIn[i] = wrData[LONG_W-1:WORD_W];
      else if (st.byteDup)  dIn[i] = {wrData[BYTE_W-1:0], wrData[BYTE_W-1:0]};
      else                  dIn[i] = wrData[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bankRegs <= '0;
      flags    <= '0;
      uspQ     <= '0;
      ispQ     <= '0;
    end else begin
      for (int i = 0; i < BANK_REGS; i++) begin
        if (st.loEn[i]) bankRegs[curBank][i][BYTE_W-1:0]      <= dIn[i][BYTE_W-1:0];
        if (st.hiEn[i]) bankRegs[curBank][i][WORD_W-1:BYTE_W] <= dIn[i][WORD_W-1:BYTE_W];
      end
      if (st.flagEn) flags <= wrData[WORD_W-1:0] & FLAG_KEEP;
      if (st.uspEn)  uspQ  <= wrData[WORD_W-1:0];
      if (st.ispEn)  ispQ  <= wrData[WORD_W-1:0];
    end
  end

  function automatic logic [LONG_W-1:0] pickReg(
    input logic [SEL_W-1:0] sel, input logic [1:0] size, input logic high,
    input logic [BANK_REGS-1:0][WORD_W-1:0] regs,
    input logic [WORD_W-1:0] flg, input logic [WORD_W-1:0] usp, input logic [WORD_W-1:0] isp);
    logic [LONG_W-1:0] res;
    res = '0;
    unique case (accSize_e'(size))
      SZ_WORD: begin
        if (sel <= SEL_FRM)      res[WORD_W-1:0] = regs[sel[2:0]];
        else if (sel == SEL_FLG) res[WORD_W-1:0] = flg;
        else if (sel == SEL_USP) res[WORD_W-1:0] = usp;
        else if (sel == SEL_ISP) res[WORD_W-1:0] = isp;
        else if (sel == SEL_SP)  res[WORD_W-1:0] = flg[STACK_BIT] ? usp : isp;
      end
      SZ_BYTE: begin
        if (sel == SEL_D0 || sel == SEL_D1)
          res[BYTE_W-1:0] = high ? regs[sel[2:0]][WORD_W-1:BYTE_W] : regs[sel[2:0]][BYTE_W-1:0];
      end
      SZ_LONG: begin
        if (sel == SEL_D0 || sel == SEL_D1)
          res = {regs[sel[2:0] + 3'd2], regs[sel[2:0]]};
        else if (sel == SEL_AD0)
          res = {regs[SEL_AD1[2:0]], regs[SEL_AD0[2:0]]};
      end
      default: res = '0;
    endcase
    return res;
  endfunction

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdPort
    always_comb rdData[p] = pickReg(rdSel[p], rdSize[p], rdHigh[p], cur, flags, uspQ, ispQ);
  end

  // R6: the bank bit moves only through a flag write
  p_bank_only_by_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !st.flagEn |=> $stable(curBank));

  // R7: reserved flag bits stay clear
  p_flag_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~FLAG_KEEP) == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bankHold
    // R6: the unselected bank is never written
    p_idle_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (curBank != 1'(b)) |=> $stable(bankRegs[b]));
  end

  for (genvar i = 0; i < 2; i++) begin : g_halfKeep
    // R3: a low byte write leaves the high byte alone, and the other way round
    p_half_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st.loEn[i] && !st.hiEn[i]) |=> $stable(bankRegs[curBank][i][WORD_W-1:BYTE_W]));
    p_half_keep_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st.hiEn[i] && !st.loEn[i]) |=> $stable(bankRegs[curBank][i][BYTE_W-1:0]));
  end
endmodule

// File: rtl/gpr_bank_file.sv
module gpr_bank_file
  import gpr_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rdSelA,
  input  logic [1:0]  rdSizeA,
  input  logic        rdHighA,
  output logic [31:0] rdDataA,
  input  logic [3:0]  rdSelB,
  input  logic [1:0]  rdSizeB,
  input  logic        rdHighB,
  output logic [31:0] rdDataB,
  input  logic        wrEn,
  input  logic [3:0]  wrSel,
  input  logic [1:0]  wrSize,
  input  logic        wrHigh,
  input  logic [31:0] wrData,
  output logic [15:0] flagsOut
);
  wrStrobe_t st;
  logic stackSel;
  logic [NUM_RD-1:0][LONG_W-1:0] rdAll;

  gpr_bank_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrSize(wrSize),
    .wrHigh(wrHigh), .stackSel(stackSel), .st(st)
  );

  gpr_bank_dp dp_i (
    .clk(clk), .rst_n(rst_n), .st(st), .wrData(wrData),
    .rdSel({rdSelB, rdSelA}), .rdSize({rdSizeB, rdSizeA}), .rdHigh({rdHighB, rdHighA}),
    .rdData(rdAll), .flags(flagsOut), .stackSel(stackSel)
  );

  assign rdDataA = rdAll[0];
  assign rdDataB = rdAll[1];
endmodule

// File: tb/gpr_bank_file_tb.sv
module gpr_bank_file_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] rdSelA = '0, rdSelB = '0, wrSel = '0;
  logic [1:0] rdSizeA = '0, rdSizeB = '0, wrSize = '0;
  logic rdHighA = 1'b0, rdHighB = 1'b0, wrEn = 1'b0, wrHigh = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB;
  logic [15:0] flagsOut;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  gpr_bank_file dut_i (
    .clk(clk), .rst_n(rst_n),
    .rdSelA(rdSelA), .rdSizeA(rdSizeA), .rdHighA(rdHighA), .rdDataA(rdDataA),
    .rdSelB(rdSelB), .rdSizeB(rdSizeB), .rdHighB(rdHighB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrSel(wrSel), .wrSize(wrSize), .wrHigh(wrHigh), .wrData(wrData),
    .flagsOut(flagsOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [1:0] size, input logic high, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrSize = size; wrHigh = high; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdA(input logic [3:0] sel, input logic [1:0] size, input logic high, output logic [31:0] v);
    rdSelA = sel; rdSizeA = size; rdHighA = high;
    #1 v = rdDataA;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    for (int s = 0; s <= 10; s++) begin
      rdA(4'(s), 2'd0, 1'b0, v);
      check("R1 reset word", v, 32'h0);
    end
    check("R1 reset flags", {16'h0, flagsOut}, 32'h0);
  endtask

  task automatic test_words();
    logic [31:0] v;
    for (int s = 0; s < 7; s++) wr(4'(s), 2'd0, 1'b0, 32'hDEAD_0000 | (32'h1000 + 32'(s) * 32'h111));
    for (int s = 0; s < 7; s++) begin
      rdA(4'(s), 2'd0, 1'b0, v);
      check("R2 word rw", v, 32'h1000 + 32'(s) * 32'h111);
    end
  endtask

  task automatic test_bytes();
    logic [31:0] v;
    for (int r = 0; r < 2; r++) begin
      wr(4'(r), 2'd0, 1'b0, 32'h1234);
      wr(4'(r), 2'd1, 1'b1, 32'h55AB);
      rdA(4'(r), 2'd0, 1'b0, v); check("R3 high byte keeps low", v, 32'hAB34);
      wr(4'(r), 2'd1, 1'b0, 32'h66CD);
      rdA(4'(r), 2'd0, 1'b0, v); check("R3 low byte keeps high", v, 32'hABCD);
      rdA(4'(r), 2'd1, 1'b1, v); check("R3 byte read high", v, 32'h00AB);
      rdA(4'(r), 2'd1, 1'b0, v); check("R3 byte read low", v, 32'h00CD);
    end
  endtask

  task automatic test_longs();
    logic [31:0] v;
    wr(4'd0, 2'd2, 1'b0, 32'h1122_3344);
    wr(4'd1, 2'd2, 1'b0, 32'h5566_7788);
    wr(4'd4, 2'd2, 1'b0, 32'h99AA_BBCC);
    rdA(4'd2, 2'd0, 1'b0, v); check("R4 D2 upper of pair", v, 32'h1122);
    rdA(4'd0, 2'd0, 1'b0, v); check("R4 D0 lower of pair", v, 32'h3344);
    rdA(4'd3, 2'd0, 1'b0, v); check("R4 D3 upper of pair", v, 32'h5566);
    rdA(4'd5, 2'd0, 1'b0, v); check("R4 AD1 upper of pair", v, 32'h99AA);
    rdA(4'd4, 2'd2, 1'b0, v); check("R4 long read AD pair", v, 32'h99AA_BBCC);
    rdA(4'd1, 2'd2, 1'b0, v); check("R4 long read D3:D1", v, 32'h5566_7788);
  endtask

  task automatic test_illegal();
    logic [31:0] v;
    wr(4'd2, 2'd1, 1'b1, 32'h00FF);
    wr(4'd3, 2'd2, 1'b0, 32'hFFFF_FFFF);
    wr(4'd0, 2'd3, 1'b0, 32'hFFFF_FFFF);
    rdA(4'd2, 2'd0, 1'b0, v); check("R5 byte to D2 ignored", v, 32'h1122);
    rdA(4'd3, 2'd0, 1'b0, v); check("R5 long to D3 ignored", v, 32'h5566);
    rdA(4'd0, 2'd0, 1'b0, v); check("R5 size3 ignored", v, 32'h3344);
    rdA(4'd2, 2'd1, 1'b0, v); check("R5 byte read D2 zero", v, 32'h0);
    rdA(4'd6, 2'd2, 1'b0, v); check("R5 long read FRM zero", v, 32'h0);
  endtask

  task automatic test_bank();
    logic [31:0] v;
    wr(4'd7, 2'd0, 1'b0, 32'h0010);
    check("R6 bank flag set", {16'h0, flagsOut}, 32'h0010);
    rdA(4'd0, 2'd0, 1'b0, v); check("R6 bank1 starts clear", v, 32'h0);
    wr(4'd0, 2'd0, 1'b0, 32'h7777);
    rdA(4'd0, 2'd0, 1'b0, v); check("R6 bank1 write", v, 32'h7777);
    wr(4'd7, 2'd0, 1'b0, 32'h0000);
    rdA(4'd0, 2'd0, 1'b0, v); check("R6 bank0 untouched", v, 32'h3344);
  endtask

  task automatic test_flags();
    logic [31:0] v;
    wr(4'd7, 2'd0, 1'b0, 32'hFFFF_FFFF);
    check("R7 flag mask", {16'h0, flagsOut}, 32'h70FF);
    rdA(4'd7, 2'd0, 1'b0, v); check("R7 flag read", v, 32'h70FF);
    wr(4'd7, 2'd0, 1'b0, 32'h0000);
  endtask

  task automatic test_stack();
    logic [31:0] v;
    wr(4'd10, 2'd0, 1'b0, 32'h0AAA);
    rdA(4'd9, 2'd0, 1'b0, v); check("R8 SP alias to ISP", v, 32'h0AAA);
    wr(4'd7, 2'd0, 1'b0, 32'h0080);
    wr(4'd10, 2'd0, 1'b0, 32'h0555);
    rdA(4'd8, 2'd0, 1'b0, v); check("R8 SP alias to USP", v, 32'h0555);
    rdA(4'd9, 2'd0, 1'b0, v); check("R8 ISP kept", v, 32'h0AAA);
    wr(4'd7, 2'd0, 1'b0, 32'h0090);
    rdA(4'd10, 2'd0, 1'b0, v); check("R8 USP shared in bank1", v, 32'h0555);
    wr(4'd7, 2'd0, 1'b0, 32'h0000);
    rdA(4'd10, 2'd0, 1'b0, v); check("R8 ISP back after clear", v, 32'h0AAA);
  endtask

  task automatic test_rdw();
    @(negedge clk);
    rdSelA = 4'd1; rdSizeA = 2'd0; rdHighA = 1'b0;
    wrEn = 1'b1; wrSel = 4'd1; wrSize = 2'd0; wrHigh = 1'b0; wrData = 32'hBEEF;
    #1 check("R9 read old during write", rdDataA, 32'h7788);
    @(posedge clk); #1;
    wrEn = 1'b0;
    #1 check("R9 new value after edge", rdDataA, 32'hBEEF);
  endtask

  task automatic test_ports();
    rdSelA = 4'd0; rdSizeA = 2'd1; rdHighA = 1'b1;
    rdSelB = 4'd0; rdSizeB = 2'd2; rdHighB = 1'b0;
    #1;
    check("R10 port A byte", rdDataA, 32'h0033);
    check("R10 port B long", rdDataB, 32'h1122_3344);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_words();
    test_bytes();
    test_longs();
    test_illegal();
    test_bank();
    test_flags();
    test_stack();
    test_rdw();
    test_ports();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule